// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Forms

This block is the purely combinational arithmetic and logic stage of a 32-bit load/store core. It takes the two register operands read for an instruction, the instruction's 16-bit immediate and 5-bit shift count, and its 6-bit primary opcode and 6-bit function code. It returns the 32-bit value to be written back and a flag that marks a zero result.

The opcode chooses between the all-register group and the immediate group. When the opcode is zero, the function code names the operation. When the opcode is one of the immediate codes, the immediate replaces the second register operand. Each immediate instruction widens the immediate in its own way: sign extension for the arithmetic and compare forms, zero extension for the bitwise forms, and placement in the upper half for the load-upper form. Add and subtract wrap silently. The block has no traps and no overflow output. Any code pair that it does not recognise produces a result of zero.

Top module: `iexec_alu`

## Requirements
- R1: With opcode 0x00, function 0x20 gives rs_val + rt_val and function 0x22 gives rs_val - rt_val, both taken modulo 2^32 with no overflow indication.
- R2: With opcode 0x00, function 0x24 gives rs_val AND rt_val, 0x25 gives rs_val OR rt_val and 0x27 gives NOT (rs_val OR rt_val), bit by bit.
- R3: Opcode 0x0C gives {16 zero bits, rs_val[15:0] AND imm16}. Opcode 0x0D gives {rs_val[31:16], rs_val[15:0] OR imm16}. In both cases rt_val has no effect.
- R4: Opcode 0x0F places imm16 in result bits 31:16 and clears bits 15:0, whatever the values of rs_val and rt_val.
- R5: With opcode 0x00, function 0x00 shifts rt_val left and function 0x02 shifts it right (logical), by shamt places, filling the vacated bits with zeros. rs_val has no effect.
- R6: With opcode 0x00, function 0x2A gives 1 when rs_val < rt_val as two's-complement numbers and 0 otherwise. Function 0x2B gives the same comparison done unsigned. Both results are exactly 0 or 1.
- R7: Opcode 0x08 gives rs_val plus imm16 sign-extended to 32 bits, modulo 2^32. rt_val has no effect.
- R8: Opcode 0x0A compares rs_val with the sign-extended imm16 as signed numbers. Opcode 0x0B compares them as unsigned numbers, with imm16 still sign-extended. The result is 1 when rs_val is less and 0 otherwise.
- R9: The zero output is 1 exactly when result equals 0x00000000.
- R10: An opcode that is not listed above, or opcode 0x00 with a function code that is not listed above, gives result 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary operation code of the instruction |
| funct | input | 6 | Function code, decoded only when opcode is zero |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand; the source for shifts |
| imm16 | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Shift count for the shift operations |
| result | output | 32 | Computed value |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so an internal fault appears at the ports in the same cycle as the input that exercises it. A wrong decode shows up as a result from a neighbouring operation. The bench spots it through operand pairs chosen so that add, sub, and, or and nor all give different values. A wrong extension rule is caught with immediates that have bit 15 set, and a wrong compare mode is caught with operands of opposite sign. Shift faults show up in the vacated bits at counts 0, 1 and 31.

// File: rtl/iexec_pkg.sv
package iexec_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR,
    OP_SLL, OP_SRL, OP_SLT, OP_SLTU, OP_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT
  } src_sel_e;
endpackage

// File: rtl/iexec_decode.sv
module iexec_decode
  import iexec_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output alu_op_e    op,
  output src_sel_e   src_sel,
  output logic       op_known
);
  always_comb begin
    op      = OP_NONE;
    src_sel = SRC_REG;
    if (opcode == OPC_RTYPE) begin
      case (funct)
        FN_ADD:  op = OP_ADD;
        FN_SUB:  op = OP_SUB;
        FN_AND:  op = OP_AND;
        FN_OR:   op = OP_OR;
        FN_NOR:  op = OP_NOR;
        FN_SLL:  op = OP_SLL;
        FN_SRL:  op = OP_SRL;
        FN_SLT:  op = OP_SLT;
        FN_SLTU: op = OP_SLTU;
        default: op = OP_NONE;
      endcase
    end else begin
      case (opcode)
        OPC_ADDI:  begin op = OP_ADD;  src_sel = SRC_SEXT; end
        OPC_SLTI:  begin op = OP_SLT;  src_sel = SRC_SEXT; end
        OPC_SLTIU: begin op = OP_SLTU; src_sel = SRC_SEXT; end
        OPC_ANDI:  begin op = OP_AND;  src_sel = SRC_ZEXT; end
        OPC_ORI:   begin op = OP_OR;   src_sel = SRC_ZEXT; end
        OPC_LUI:   begin op = OP_LUI;  src_sel = SRC_ZEXT; end
        default:   begin op = OP_NONE; src_sel = SRC_REG;  end
      endcase
    end
    op_known = (op != OP_NONE);
  end
endmodule

// File: rtl/iexec_opnd.sv
module iexec_opnd
  import iexec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  src_sel_e          src_sel,
  output logic [DATA_W-1:0] opb
);
  localparam int EXT_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{EXT_W{1'b0}}, v};
  endfunction

  always_comb begin
    case (src_sel)
      SRC_SEXT: opb = f_sext(imm);
      SRC_ZEXT: opb = f_zext(imm);
      default:  opb = rt_val;
    endcase
  end
endmodule

// File: rtl/iexec_core.sv
module iexec_core
  import iexec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = 5
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result
);
  localparam int UP_SH = DATA_W - IMM_W;

  function automatic logic f_less(input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b,
                                  input logic              signed_mode);
    logic ult;
    ult = (a < b);
    if (signed_mode && (a[DATA_W-1] != b[DATA_W-1]))
      return a[DATA_W-1];
    return ult;
  endfunction

  logic is_compare;
  logic [DATA_W-1:0] keep_mask;

  always_comb begin
    case (op)
      OP_ADD:  result = opa + opb;
      OP_SUB:  result = opa - opb;
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_NOR:  result = ~(opa | opb);
      OP_SLL:  result = opb << shamt;
      OP_SRL:  result = opb >> shamt;
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, f_less(opa, opb, 1'b1)};
      OP_SLTU: result = {{(DATA_W-1){1'b0}}, f_less(opa, opb, 1'b0)};
      OP_LUI:  result = opb << UP_SH;
      default: result = '0;
    endcase
  end

  assign is_compare = (op == OP_SLT) || (op == OP_SLTU);
  assign keep_mask  = {DATA_W{1'b1}} << shamt;

  always_comb begin
    if (is_compare)
      a_r6_bool_result: assert (result[DATA_W-1:1] == '0);
    if (op == OP_SLL)
      a_r5_sll_low_clear: assert ((result & ~keep_mask) == '0);
    if (op == OP_SRL)
      a_r5_srl_high_clear: assert ((result & ~(keep_mask >> shamt) & ~({DATA_W{1'b1}} >> shamt)) == '0);
    if (op == OP_LUI)
      a_r4_upper_low_clear: assert (result[UP_SH-1:0] == '0);
  end
endmodule

// File: rtl/iexec_alu.sv
module iexec_alu
  import iexec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = 5
) (
  input  logic [5:0]        opcode,
  input  logic [5:0]        funct,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  alu_op_e           dec_op;
  src_sel_e          dec_src;
  logic              dec_known;
  logic [DATA_W-1:0] opnd_b;

  iexec_decode u_decode (
    .opcode   (opcode),
    .funct    (funct),
    .op       (dec_op),
    .src_sel  (dec_src),
    .op_known (dec_known)
  );

  iexec_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .rt_val  (rt_val),
    .imm     (imm16),
    .src_sel (dec_src),
    .opb     (opnd_b)
  );

  iexec_core #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_core (
    .op     (dec_op),
    .opa    (rs_val),
    .opb    (opnd_b),
    .shamt  (shamt),
    .result (result)
  );

  assign zero = ~|result;

  always_comb begin
    if (!dec_known)
      a_r10_unknown_gives_zero: assert (result == '0 && zero);
    if (opcode == OPC_ANDI)
      a_r3_andi_upper_clear: assert (result[DATA_W-1:IMM_W] == '0);
    if (opcode == OPC_ORI)
      a_r3_ori_upper_pass: assert (result[DATA_W-1:IMM_W] == rs_val[DATA_W-1:IMM_W]);
    if (opcode == OPC_LUI)
      a_r4_upper_holds_imm: assert (result[DATA_W-1:DATA_W-IMM_W] == imm16);
  end
endmodule

// File: tb/iexec_alu_tb.sv
module iexec_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int failures = 0;

  logic [31:0] q_res[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iexec_alu u_dut (
    .opcode (opcode),
    .funct  (funct),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .imm16  (imm16),
    .shamt  (shamt),
    .result (result),
    .zero   (zero)
  );

  // reference built from the requirements, written independently
  function automatic logic [31:0] model(input logic [5:0] oc, input logic [5:0] fn,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] se;
    se = 32'($signed(im));
    if (oc == 6'h00) begin
      if (fn == 6'h20) return a + b;
      if (fn == 6'h22) return a + ~b + 32'd1;
      if (fn == 6'h24) return a & b;
      if (fn == 6'h25) return a | b;
      if (fn == 6'h27) return ~a & ~b;
      if (fn == 6'h00) return b << sh;
      if (fn == 6'h02) return b >> sh;
      if (fn == 6'h2A) return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      if (fn == 6'h2B) return ($unsigned(a) < $unsigned(b)) ? 32'd1 : 32'd0;
      return 32'd0;
    end
    if (oc == 6'h08) return a + se;
    if (oc == 6'h0A) return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
    if (oc == 6'h0B) return (a < se) ? 32'd1 : 32'd0;
    if (oc == 6'h0C) return {16'h0, a[15:0] & im};
    if (oc == 6'h0D) return {a[31:16], a[15:0] | im};
    if (oc == 6'h0F) return {im, 16'h0};
    return 32'd0;
  endfunction

  task automatic drive(input logic [5:0] oc, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       input logic [31:0] exp, input string tag);
    @(posedge clk);
    #1;
    opcode = oc; funct = fn; rs_val = a; rt_val = b; imm16 = im; shamt = sh;
    q_res.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic drive_m(input logic [5:0] oc, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         input string tag);
    drive(oc, fn, a, b, im, sh, model(oc, fn, a, b, im, sh), tag);
  endtask

  // monitor: pop expected and compare away from the driving edge
  always @(negedge clk) begin
    if (q_res.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_res.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (result !== e) begin
        failures++;
        $display("FAIL %s result actual=%08h expected=%08h", t, result, e);
      end
      checks++;
      if (zero !== (e == 32'd0)) begin
        failures++;
        $display("FAIL R9 zero flag (%s) actual=%0b expected=%0b", t, zero, (e == 32'd0));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // initial state: all-zero inputs decode as sll by 0 of zero
    drive(6'h00, 6'h00, 32'h0, 32'h0, 16'h0, 5'd0, 32'h0, "R5 R9 idle");
    // R1 add/sub wrap
    drive(6'h00, 6'h20, 32'hFFFFFFFF, 32'h00000002, 16'h0, 5'd0, 32'h00000001, "R1 add wrap");
    drive(6'h00, 6'h22, 32'h00000001, 32'h00000002, 16'h0, 5'd0, 32'hFFFFFFFF, "R1 sub wrap");
    drive(6'h00, 6'h22, 32'h12345678, 32'h12345678, 16'h0, 5'd0, 32'h0, "R1 R9 sub equal");
    // R2 bitwise
    drive(6'h00, 6'h24, 32'h12345678, 32'hCAFEFACE, 16'h0, 5'd0, 32'h02345248, "R2 and");
    drive(6'h00, 6'h25, 32'h12345678, 32'hCAFEFACE, 16'h0, 5'd0, 32'hDAFEFEFE, "R2 or");
    drive(6'h00, 6'h27, 32'h12345678, 32'hCAFEFACE, 16'h0, 5'd0, 32'h25010101, "R2 nor");
    drive(6'h00, 6'h27, 32'h0, 32'h0, 16'h0, 5'd0, 32'hFFFFFFFF, "R2 nor as not");
    // R3 andi/ori, rt ignored
    drive(6'h0C, 6'h00, 32'h12345678, 32'hFFFFFFFF, 16'd2020, 5'd0, 32'h00000660, "R3 andi");
    drive(6'h0C, 6'h00, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, 32'h00008001, "R3 andi zext");
    drive(6'h0D, 6'h00, 32'hABCD0000, 32'h5555AAAA, 16'h8421, 5'd0, 32'hABCD8421, "R3 ori");
    // R4 lui
    drive(6'h0F, 6'h00, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 5'd0, 32'h12340000, "R4 lui");
    drive(6'h0F, 6'h3F, 32'h1, 32'h1, 16'h0000, 5'd7, 32'h0, "R4 R9 lui zero");
    // R5 shifts, rs ignored
    drive(6'h00, 6'h00, 32'hFFFFFFFF, 32'h12345678, 16'h0, 5'd4, 32'h23456780, "R5 sll 4");
    drive(6'h00, 6'h00, 32'h0, 32'h80000001, 16'h0, 5'd31, 32'h80000000, "R5 sll 31");
    drive(6'h00, 6'h02, 32'hFFFFFFFF, 32'h80000000, 16'h0, 5'd31, 32'h00000001, "R5 srl 31");
    drive(6'h00, 6'h02, 32'h0, 32'hF0000000, 16'h0, 5'd1, 32'h78000000, "R5 srl zero fill");
    drive(6'h00, 6'h02, 32'h0, 32'hA5A5A5A5, 16'h0, 5'd0, 32'hA5A5A5A5, "R5 srl 0");
    // R6 set-less-than
    drive(6'h00, 6'h2A, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h1, "R6 slt signed");
    drive(6'h00, 6'h2B, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h0, "R6 sltu unsigned");
    drive(6'h00, 6'h2A, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd0, 32'h0, "R6 slt extremes");
    drive(6'h00, 6'h2B, 32'h5, 32'h5, 16'h0, 5'd0, 32'h0, "R6 sltu equal");
    // R7 addi sign extension, rt ignored
    drive(6'h08, 6'h00, 32'h00000010, 32'hFFFFFFFF, 16'hFFFF, 5'd0, 32'h0000000F, "R7 addi negative");
    drive(6'h08, 6'h00, 32'hFFFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h0, "R7 R9 addi wrap");
    // R8 slti / sltiu
    drive(6'h0A, 6'h00, 32'h00000000, 32'h0, 16'hFFFF, 5'd0, 32'h0, "R8 slti 0<-1");
    drive(6'h0B, 6'h00, 32'h00000000, 32'h0, 16'hFFFF, 5'd0, 32'h1, "R8 sltiu 0<FFFFFFFF");
    drive(6'h0B, 6'h00, 32'hFFFFFFF0, 32'h0, 16'h8000, 5'd0, 32'h0, "R8 sltiu sext high");
    drive(6'h0A, 6'h00, 32'hFFFF8000, 32'h0, 16'h7FFF, 5'd0, 32'h1, "R8 slti signed");
    // R10 unknown codes
    drive(6'h01, 6'h20, 32'h1, 32'h2, 16'h3, 5'd1, 32'h0, "R10 unknown opcode");
    drive(6'h00, 6'h21, 32'h1, 32'h2, 16'h3, 5'd1, 32'h0, "R10 unknown funct");
    drive(6'h23, 6'h00, 32'hFFFF, 32'hFFFF, 16'hFFFF, 5'd3, 32'h0, "R10 load opcode");
    // mixed patterns against the model
    for (int i = 0; i < 300; i++) begin
      logic [5:0] oc, fn;
      int k;
      k = int'($urandom_range(0, 15));
      oc = 6'h00; fn = 6'h20;
      case (k)
        0: fn = 6'h20;  1: fn = 6'h22;  2: fn = 6'h24;  3: fn = 6'h25;
        4: fn = 6'h27;  5: fn = 6'h00;  6: fn = 6'h02;  7: fn = 6'h2A;
        8: fn = 6'h2B;  9: oc = 6'h08; 10: oc = 6'h0A; 11: oc = 6'h0B;
        12: oc = 6'h0C; 13: oc = 6'h0D; 14: oc = 6'h0F;
        default: oc = 6'h3E;
      endcase
      drive_m(oc, fn, $urandom, $urandom, 16'($urandom), 5'($urandom),
              "R1 R2 R3 R4 R5 R6 R7 R8 R10 mixed");
    end
    while (q_res.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule